// File: doc/BRIEF.md
# Masked Test Data Path with Stream Cipher

This block sits on one core's slice of a shared 32-bit parallel test bus. It hides that core's test traffic from every other core on the same wiring. A nonlinear feedback keystream generator provides the masks. It has a 288-bit state, an 80-bit secret key and an 80-bit initial value. Each accepted test transfer consumes 64 keystream bits. The first 32 bits unmask the stimulus word that arrives from the tester. The second 32 bits mask the response word that goes back. Both XOR paths are purely combinational, so the test path gains no latency and no pipeline stage.

Testing starts with a one-cycle `start_i` pulse. The pulse loads the key and the initial value into the generator state. The generator then makes 1152 state updates whose output is thrown away, 64 updates per clock. After that it raises `armed_o`. From then on the state advances by 64 steps only in cycles where `beat_i` marks a valid test transfer. An external tester running the same generator therefore stays in lockstep with the wrapper, even when the bus has idle cycles. Before `armed_o` is high, data passes through unchanged and `xfer_ok_o` stays low.

Top module: `tdw_cipher_top`

## Requirements
- R1: After reset `armed_o` and `xfer_ok_o` are 0, and both data outputs equal their inputs.
- R2: A cycle with `start_i` high loads the state as follows, with state positions numbered 1 to 288. `key_i[i]` goes to position i+1. `nonce_i[i]` goes to position i+94. Positions 286, 287 and 288 are set to 1. Every other position is 0.
- R3: `armed_o` becomes 1 exactly 18 clock edges after the edge that samples `start_i` (1152 updates at 64 per edge). A new `start_i` pulse clears `armed_o` at the next edge.
- R4: While `armed_o` is 0, `stim_o` equals `stim_i` and `resp_o` equals `resp_i`, whatever `beat_i` is. `beat_i` does not change the warm-up.
- R5: The keystream advances only at edges where `armed_o` and `beat_i` are both 1. In cycles with `beat_i` low, the data passes unmasked and the keystream position is kept.
- R6: In an accepted transfer, bit j of `stim_o` is `stim_i[j]` XOR the j-th output bit (j = 0..31) of that transfer's 64-step run.
- R7: In an accepted transfer, bit j of `resp_o` is `resp_i[j]` XOR output bit 32+j of the same run.
- R8: The masking is combinational. Outputs reflect inputs and the current keystream in the same cycle.
- R9: One state update works as follows, with s(n) denoting position n:
  - a = s66^s93, b = s162^s177, c = s243^s288, and the output bit is a^b^c.
  - Position 1 takes c^(s286&s287)^s69.
  - Position 94 takes a^(s91&s92)^s171.
  - Position 178 takes b^(s175&s176)^s264.
  - Every other position takes the value of its lower neighbour inside its own register (1-93, 94-177, 178-288).
- R10: `xfer_ok_o` is `armed_o` AND `beat_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load key and initial value and begin warm-up |
| key_i | input | 80 | Secret key from the key-setup register |
| nonce_i | input | 80 | Initial value for the session |
| beat_i | input | 1 | Valid strobe for the current test transfer |
| stim_i | input | 32 | Masked stimulus word from the test bus |
| resp_i | input | 32 | Plain response word from the core |
| stim_o | output | 32 | Unmasked stimulus word toward the core |
| resp_o | output | 32 | Masked response word toward the test bus |
| armed_o | output | 1 | Warm-up done, keystream in use |
| xfer_ok_o | output | 1 | Current transfer is masked and valid |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 64-bit keystream per transfer and 1152 warm-up updates. These are the values the masking is meant to run with, and with a bit-serial model of the generator in the bench they keep every session short enough to sweep many keys. Six key and initial-value pairs, including all-zero, all-one and walking patterns, each go through warm-up and then dozens of transfers. The transfers include idle gaps, round trips in which the tester encrypts and then decrypts, and a re-start in the middle of a session.

// File: rtl/tdw_cipher_pkg.sv
package tdw_cipher_pkg;

    localparam int STATE_W = 288;
    localparam int KEY_W   = 80;

    // One update of the generator: returns {output_bit, next_state}.
    // Vector bit n-1 holds state position n.
    function automatic logic [STATE_W:0] nlfsr_step(input logic [STATE_W-1:0] s);
        logic a, b, c, z;
        logic [STATE_W-1:0] n;
        a = s[65]  ^ s[92];
        b = s[161] ^ s[176];
        c = s[242] ^ s[287];
        z = a ^ b ^ c;
        n            = '0;
        n[0]         = c ^ (s[285] & s[286]) ^ s[68];
        n[92:1]      = s[91:0];
        n[93]        = a ^ (s[90] & s[91]) ^ s[170];
        n[176:94]    = s[175:93];
        n[177]       = b ^ (s[174] & s[175]) ^ s[263];
        n[287:178]   = s[286:177];
        return {z, n};
    endfunction

    function automatic logic [STATE_W-1:0] seed_state(input logic [KEY_W-1:0] k,
                                                      input logic [KEY_W-1:0] v);
        return {3'b111, 108'd0, 4'd0, v, 13'd0, k};
    endfunction

endpackage

// File: rtl/tdw_keystream.sv
module tdw_keystream
    import tdw_cipher_pkg::*;
#(
    parameter int LANES      = 64,
    parameter int WARM_STEPS = 1152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEY_W-1:0]  key,
    input  logic [KEY_W-1:0]  nonce,
    input  logic              advance,
    output logic              armed,
    output logic [LANES-1:0]  ks
);
    localparam int WARM_CYC = (WARM_STEPS + LANES - 1) / LANES;
    localparam int CW       = $clog2(WARM_CYC + 1);

    typedef struct packed {
        logic [STATE_W-1:0] st;
        logic [CW-1:0]      cnt;
        logic               warm;
        logic               rdy;
    } gen_t;

    gen_t q, d;
    logic [STATE_W-1:0] st_run;

    // LANES chained updates: keystream bits and the advanced state
    always_comb begin
        logic [STATE_W-1:0] s;
        logic [STATE_W:0]   r;
        s = q.st;
        ks = '0;
        for (int i = 0; i < LANES; i++) begin
            r     = nlfsr_step(s);
            ks[i] = r[STATE_W];
            s     = r[STATE_W-1:0];
        end
        st_run = s;
    end

    always_comb begin
        d = q;
        if (start) begin
            d.st   = seed_state(key, nonce);
            d.cnt  = CW'(WARM_CYC);
            d.warm = 1'b1;
            d.rdy  = 1'b0;
        end else if (q.warm) begin
            d.st  = st_run;
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.warm = 1'b0;
                d.rdy  = 1'b1;
            end
        end else if (q.rdy && advance) begin
            d.st = st_run;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed = q.rdy;

    assert_start_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !armed);
    assert_arm_after_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rdy) |-> ($past(q.cnt) == CW'(1)));
    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rdy && !advance && !start) |=> $stable(q.st));
    assert_warm_excl_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.warm && q.rdy));

endmodule

// File: rtl/tdw_xor_lane.sv
module tdw_xor_lane #(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] mask_s,
    input  logic [DATA_W-1:0] mask_r,
    input  logic [DATA_W-1:0] stim_in,
    input  logic [DATA_W-1:0] resp_in,
    output logic [DATA_W-1:0] stim_out,
    output logic [DATA_W-1:0] resp_out
);
    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        assign stim_out[j] = stim_in[j] ^ (en & mask_s[j]);
        assign resp_out[j] = resp_in[j] ^ (en & mask_r[j]);
    end
endmodule

// File: rtl/tdw_cipher_top.sv
module tdw_cipher_top
    import tdw_cipher_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WARM_STEPS = 1152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [79:0]       key_i,
    input  logic [79:0]       nonce_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] stim_i,
    input  logic [DATA_W-1:0] resp_i,
    output logic [DATA_W-1:0] stim_o,
    output logic [DATA_W-1:0] resp_o,
    output logic              armed_o,
    output logic              xfer_ok_o
);
    localparam int LANES = 2 * DATA_W;

    logic [LANES-1:0] ks;
    logic             armed;

    tdw_keystream #(.LANES(LANES), .WARM_STEPS(WARM_STEPS)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .key     (key_i),
        .nonce   (nonce_i),
        .advance (beat_i),
        .armed   (armed),
        .ks      (ks)
    );

    tdw_xor_lane #(.DATA_W(DATA_W)) u_xor (
        .en       (armed & beat_i),
        .mask_s   (ks[DATA_W-1:0]),
        .mask_r   (ks[LANES-1:DATA_W]),
        .stim_in  (stim_i),
        .resp_in  (resp_i),
        .stim_out (stim_o),
        .resp_out (resp_o)
    );

    assign armed_o   = armed;
    assign xfer_ok_o = armed & beat_i;

    assert_clear_until_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |-> (stim_o == stim_i && resp_o == resp_i));
    assert_idle_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_i |-> (stim_o == stim_i && resp_o == resp_i && !xfer_ok_o));
    assert_flag_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ok_o |-> armed_o);

endmodule

// File: tb/tdw_cipher_top_tb_top.sv
module tdw_cipher_top_tb_top;
    localparam int DW   = 32;
    localparam int WCYC = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [79:0] key_i = '0, nonce_i = '0;
    logic beat_i = 1'b0;
    logic [DW-1:0] stim_i = '0, resp_i = '0;
    logic [DW-1:0] stim_o, resp_o;
    logic armed_o, xfer_ok_o;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tdw_cipher_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .nonce_i(nonce_i), .beat_i(beat_i), .stim_i(stim_i), .resp_i(resp_i),
        .stim_o(stim_o), .resp_o(resp_o), .armed_o(armed_o), .xfer_ok_o(xfer_ok_o)
    );

    // Bit-serial reference generator, positions 1..288
    bit rs [1:288];

    task automatic ref_load(input logic [79:0] k, input logic [79:0] v);
        for (int p = 1; p <= 288; p++) rs[p] = 1'b0;
        for (int p = 1; p <= 80; p++) begin
            rs[p]      = k[p-1];
            rs[p + 93] = v[p-1];
        end
        rs[286] = 1'b1; rs[287] = 1'b1; rs[288] = 1'b1;
    endtask

    task automatic ref_bit(output bit z);
        bit a, b, c, na, nb, nc;
        a = rs[66] ^ rs[93];
        b = rs[162] ^ rs[177];
        c = rs[243] ^ rs[288];
        z = a ^ b ^ c;
        na = a ^ (rs[91] & rs[92]) ^ rs[171];
        nb = b ^ (rs[175] & rs[176]) ^ rs[264];
        nc = c ^ (rs[286] & rs[287]) ^ rs[69];
        for (int p = 288; p > 178; p--) rs[p] = rs[p-1];
        for (int p = 177; p > 94; p--)  rs[p] = rs[p-1];
        for (int p = 93; p > 1; p--)    rs[p] = rs[p-1];
        rs[1] = nc; rs[94] = na; rs[178] = nb;
    endtask

    task automatic ref_words(output logic [31:0] ms, output logic [31:0] mr);
        bit z;
        for (int j = 0; j < 32; j++) begin ref_bit(z); ms[j] = z; end
        for (int j = 0; j < 32; j++) begin ref_bit(z); mr[j] = z; end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle of bus traffic; v=1 means a transfer from the tester
    task automatic bus_cycle(input bit v, input logic [31:0] plain, input logic [31:0] rsp);
        logic [31:0] ms, mr;
        bit use_ks;
        @(negedge clk);
        use_ks = armed_o && v;
        ms = '0; mr = '0;
        if (use_ks) ref_words(ms, mr);
        beat_i = v;
        stim_i = plain ^ ms;       // tester encrypts
        resp_i = rsp;
        #1;
        check(stim_o == plain, use_ks ? "R6" : "R5", "stim round trip", stim_o, plain);
        check(resp_o == (rsp ^ mr), use_ks ? "R7" : "R5", "resp mask", resp_o, rsp ^ mr);
        check(((resp_o ^ mr) == rsp), "R8", "same-cycle decrypt", resp_o ^ mr, rsp);
        check(xfer_ok_o == use_ks, "R10", "xfer flag", {31'd0, xfer_ok_o}, {31'd0, use_ks});
    endtask

    task automatic begin_session(input logic [79:0] k, input logic [79:0] v);
        bit z;
        @(negedge clk);
        key_i = k; nonce_i = v; start_i = 1'b1; beat_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(armed_o == 1'b0, "R3", "disarmed after start", {31'd0, armed_o}, 32'd0);
        ref_load(k, v);
        for (int s = 0; s < 1152; s++) ref_bit(z);
        for (int j = 0; j < WCYC; j++) begin
            if (j > 0) @(negedge clk);
            beat_i = j[0];
            stim_i = 32'hA5A5_0000 + j;
            resp_i = 32'h0F0F_0000 ^ j;
            #1;
            check(armed_o == 1'b0, "R3", "armed early", {31'd0, armed_o}, 32'd0);
            check(stim_o == stim_i && resp_o == resp_i, "R4", "warm-up passthrough",
                  stim_o, stim_i);
        end
        @(negedge clk);
        beat_i = 1'b0;
        #1;
        check(armed_o == 1'b1, "R3", "armed after 18 edges", {31'd0, armed_o}, 32'd1);
    endtask

    initial begin
        logic [79:0] keys [6];
        logic [79:0] ivs  [6];
        keys[0] = '0;                     ivs[0] = '0;
        keys[1] = '1;                     ivs[1] = '1;
        keys[2] = 80'h1;                  ivs[2] = 80'h8000_0000_0000_0000_0000;
        keys[3] = 80'h0123_4567_89AB_CDEF_F00D; ivs[3] = 80'h5555_AAAA_5555_AAAA_5555;
        keys[4] = 80'hFFFF_0000_FFFF_0000_FFFF; ivs[4] = 80'h0;
        keys[5] = 80'h8000_0000_0000_0000_0001; ivs[5] = 80'h3C3C_3C3C_3C3C_3C3C_3C3C;

        repeat (3) @(negedge clk);
        stim_i = 32'hDEAD_BEEF; resp_i = 32'h1234_5678; beat_i = 1'b1;
        #1;
        // R1: reset state
        check(armed_o == 1'b0 && xfer_ok_o == 1'b0, "R1", "reset flags",
              {30'd0, armed_o, xfer_ok_o}, 32'd0);
        check(stim_o == stim_i && resp_o == resp_i, "R1", "reset passthrough", stim_o, stim_i);
        @(negedge clk);
        rst_n = 1'b1;

        for (int t = 0; t < 6; t++) begin
            // R2 R9: each session checks the seed layout and update rule via masks
            begin_session(keys[t], ivs[t]);
            for (int w = 0; w < 40; w++) begin
                logic [31:0] p, r;
                p = (t + 1) * 32'h9E37_79B9 + w * 32'h0101_0101;
                r = ~p ^ (w << 3);
                bus_cycle((w % 5) != 3, p, r);   // gaps exercise R5
            end
        end

        // R3: re-start mid-session clears arm at the next edge
        @(negedge clk);
        start_i = 1'b1; key_i = keys[3]; nonce_i = ivs[0];
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(armed_o == 1'b0, "R3", "restart disarms", {31'd0, armed_o}, 32'd0);
        begin_session(keys[3], ivs[0]);
        for (int w = 0; w < 20; w++) bus_cycle(1'b1, 32'hC001_0000 + w, 32'h0BAD_0000 + w);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule